// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on a host I/O bus and gives the host indirect access to the configuration registers of up to 32 device slots. The host first writes a 32-bit address word to a single I/O port. The word selects a register index, a function number, a device slot and a bus number, and it carries an enable flag. The host then makes byte accesses to a four-port data window. Each byte access becomes a configuration request to the selected slot. The block returns the slot's read byte, or all-ones when the access is not forwarded or no device answers.

Requests leave the block in the same cycle as the host access that causes them. They carry a one-hot slot select, the function number, a byte-level register offset and the write byte. The slot's read byte and a per-slot presence flag come back combinationally and are folded into the host read data.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the address word reads back as 0, so enable is clear.
- R2: A host write to port 0xCF8 latches the word at the next clock edge. Index is bits 7:0, function bits 10:8, device bits 15:11, bus bits 23:16 and enable bit 31. A read of 0xCF8 returns those fields in the same positions, and bits 30:24 always read 0.
- R3: A host access to port 0xCFC+k (k = 0..3), made while enable is 1 and bus is 0, raises `dev_req_o` in that same cycle. `dev_sel_o` has only the bit for the latched device set, `dev_func_o` carries the latched function, and `dev_offset_o` equals the latched index OR k.
- R4: A forwarded write sets `dev_we_o` and puts `io_wdata_i[7:0]` on `dev_wdata_o`. A forwarded read leaves `dev_we_o` low.
- R5: While enable is 0, a data-window access raises no request, and a data-window read returns 0x000000FF.
- R6: While the bus field is nonzero, a data-window access raises no request, and a data-window read returns 0x000000FF.
- R7: A forwarded read returns the selected slot's byte in bits 7:0 with zeros above when the slot's present flag is set. It returns 0x000000FF when the flag is clear.
- R8: An access to any other port raises no request and leaves the address word unchanged. A read of such a port returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_valid_i | input | 1 | Host I/O access strobe, one cycle per access |
| io_we_i | input | 1 | Host access is a write |
| io_addr_i | input | 16 | Host I/O port address |
| io_wdata_i | input | 32 | Host write data: full word for the address port, bits 7:0 for the window |
| io_rdata_o | output | 32 | Host read data, valid in the cycle of the access |
| dev_req_o | output | 1 | Configuration request strobe |
| dev_we_o | output | 1 | Request is a write |
| dev_sel_o | output | 32 | One-hot slot select |
| dev_func_o | output | 3 | Function number |
| dev_offset_o | output | 8 | Byte register offset |
| dev_wdata_o | output | 8 | Write byte |
| dev_rdata_i | input | 256 | Read byte of each slot, slot n at bits 8n+7:8n |
| dev_present_i | input | 32 | Per-slot responder present flag |

## Verification
The assertions assume that `io_valid_i` is a single-cycle strobe that is stable around the clock edge. They also assume that slot read data and present flags settle combinationally within the cycle. They take the port constants to be the defaults, and they take the data window to be four-port aligned. The bench drives every host access at the falling edge, holds it for exactly one cycle and then idles one cycle. It keeps the slot read bytes and present flags static during a run, so each combinational result is stable when it is sampled.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned FUNC_W = 3;
  localparam int unsigned DEV_W  = 5;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned LANE_W = 2;

  // bits 30:24 of the address word are not stored
  localparam logic [WORD_W-1:0] ADDR_MASK = 32'h80FF_FFFF;

  typedef struct packed {
    logic              en;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [IDX_W-1:0]  idx;
  } cfg_addr_t;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADDR = 2'd1,
    ACC_WIN  = 2'd2
  } acc_e;
endpackage

// File: rtl/cfg_port_classify.sv
module cfg_port_classify
  import cfg_port_pkg::*;
#(
  parameter int unsigned       IO_AW     = 16,
  parameter logic [IO_AW-1:0]  ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0]  DATA_PORT = 16'h0CFC
) (
  input  logic              valid_i,
  input  logic [IO_AW-1:0]  addr_i,
  output acc_e              kind_o,
  output logic [LANE_W-1:0] lane_o
);
  always_comb begin
    kind_o = ACC_NONE;
    if (valid_i) begin
      if (addr_i == ADDR_PORT)
        kind_o = ACC_ADDR;
      else if (addr_i[IO_AW-1:LANE_W] == DATA_PORT[IO_AW-1:LANE_W])
        kind_o = ACC_WIN;
    end
  end

  assign lane_o = addr_i[LANE_W-1:0];
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] word_o,
  output cfg_addr_t         fields_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (wr_i) word_q <= wdata_i & ADDR_MASK;
  end

  assign word_o        = word_q;
  assign fields_o.en   = word_q[31];
  assign fields_o.bus  = word_q[23:16];
  assign fields_o.dev  = word_q[15:11];
  assign fields_o.func = word_q[10:8];
  assign fields_o.idx  = word_q[7:0];
endmodule

// File: rtl/cfg_window_fwd.sv
module cfg_window_fwd
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  acc_e              kind_i,
  input  logic              we_i,
  input  logic [LANE_W-1:0] lane_i,
  input  cfg_addr_t         fields_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic              req_o,
  output logic              we_o,
  output logic [NUM_SLOTS-1:0] sel_o,
  output logic [FUNC_W-1:0] func_o,
  output logic [IDX_W-1:0]  off_o,
  output logic [BYTE_W-1:0] wdata_o
);
  logic fwd_ok;

  // forward only on the local bus with the enable set
  assign fwd_ok = fields_i.en && (fields_i.bus == '0);
  assign req_o  = (kind_i == ACC_WIN) && fwd_ok;
  assign we_o   = req_o && we_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
    assign sel_o[g] = req_o && (fields_i.dev == DEV_W'(g));
  end

  assign func_o  = req_o ? fields_i.func : '0;
  assign off_o   = req_o ? (fields_i.idx | IDX_W'(lane_i)) : '0;
  assign wdata_o = (req_o && we_i) ? wbyte_i : '0;
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_port_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  logic [NUM_SLOTS-1:0]        sel_i,
  input  logic [NUM_SLOTS-1:0]        present_i,
  input  logic [NUM_SLOTS*BYTE_W-1:0] rdata_i,
  output logic [BYTE_W-1:0]           byte_o
);
  logic [BYTE_W-1:0] acc;
  logic              hit;

  always_comb begin
    acc = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel_i[i] && present_i[i]) begin
        acc = acc | rdata_i[i*BYTE_W +: BYTE_W];
        hit = 1'b1;
      end
    end
  end

  assign byte_o = hit ? acc : '1;
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter int unsigned      NUM_SLOTS = 32,
  parameter int unsigned      IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        io_valid_i,
  input  logic                        io_we_i,
  input  logic [IO_AW-1:0]            io_addr_i,
  input  logic [31:0]                 io_wdata_i,
  output logic [31:0]                 io_rdata_o,
  output logic                        dev_req_o,
  output logic                        dev_we_o,
  output logic [NUM_SLOTS-1:0]        dev_sel_o,
  output logic [2:0]                  dev_func_o,
  output logic [7:0]                  dev_offset_o,
  output logic [7:0]                  dev_wdata_o,
  input  logic [NUM_SLOTS*8-1:0]      dev_rdata_i,
  input  logic [NUM_SLOTS-1:0]        dev_present_i
);
  acc_e              kind;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] addr_word;
  cfg_addr_t         addr_fields;
  logic [BYTE_W-1:0] slot_byte;

  cfg_port_classify #(
    .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) i_classify (
    .valid_i(io_valid_i),
    .addr_i (io_addr_i),
    .kind_o (kind),
    .lane_o (lane)
  );

  cfg_addr_reg i_addr_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    ((kind == ACC_ADDR) && io_we_i),
    .wdata_i (io_wdata_i),
    .word_o  (addr_word),
    .fields_o(addr_fields)
  );

  cfg_window_fwd #(.NUM_SLOTS(NUM_SLOTS)) i_fwd (
    .kind_i  (kind),
    .we_i    (io_we_i),
    .lane_i  (lane),
    .fields_i(addr_fields),
    .wbyte_i (io_wdata_i[BYTE_W-1:0]),
    .req_o   (dev_req_o),
    .we_o    (dev_we_o),
    .sel_o   (dev_sel_o),
    .func_o  (dev_func_o),
    .off_o   (dev_offset_o),
    .wdata_o (dev_wdata_o)
  );

  cfg_read_mux #(.NUM_SLOTS(NUM_SLOTS)) i_rmux (
    .sel_i    (dev_sel_o),
    .present_i(dev_present_i),
    .rdata_i  (dev_rdata_i),
    .byte_o   (slot_byte)
  );

  always_comb begin
    unique case (kind)
      ACC_ADDR: io_rdata_o = addr_word;
      ACC_WIN:  io_rdata_o = {24'h0, (dev_req_o ? slot_byte : 8'hFF)};
      default:  io_rdata_o = '1;
    endcase
  end
endmodule

module cfg_port_decoder_chk #(
  parameter int unsigned      NUM_SLOTS = 32,
  parameter int unsigned      IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 io_valid_i,
  input logic                 io_we_i,
  input logic [IO_AW-1:0]     io_addr_i,
  input logic [31:0]          io_wdata_i,
  input logic [31:0]          io_rdata_o,
  input logic                 dev_req_o,
  input logic                 dev_we_o,
  input logic [NUM_SLOTS-1:0] dev_sel_o,
  input logic [NUM_SLOTS-1:0] dev_present_i,
  input logic [31:0]          addr_word
);
  logic other_port;
  assign other_port = io_valid_i && (io_addr_i != ADDR_PORT) &&
                      (io_addr_i[IO_AW-1:2] != DATA_PORT[IO_AW-1:2]);

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_clear_R1: assert (addr_word == 32'h0);

  assert_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_i && io_we_i && io_addr_i == ADDR_PORT)
      |=> (addr_word == ($past(io_wdata_i) & 32'h80FF_FFFF)));

  assert_sel_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o |-> ($countones(dev_sel_o) <= 1));

  assert_idle_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_req_o |-> (dev_sel_o == '0) && !dev_we_o);

  assert_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_word[31] |-> !dev_req_o);

  assert_bus_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_word[23:16] != 8'h0) |-> !dev_req_o);

  assert_absent_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_req_o && !io_we_i && ((dev_sel_o & dev_present_i) == '0))
      |-> (io_rdata_o == 32'h0000_00FF));

  assert_other_noreq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_port |-> !dev_req_o && (io_rdata_o == 32'hFFFF_FFFF));

  assert_other_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_port |=> $stable(addr_word));
endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(
  .NUM_SLOTS(NUM_SLOTS), .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .io_valid_i   (io_valid_i),
  .io_we_i      (io_we_i),
  .io_addr_i    (io_addr_i),
  .io_wdata_i   (io_wdata_i),
  .io_rdata_o   (io_rdata_o),
  .dev_req_o    (dev_req_o),
  .dev_we_o     (dev_we_o),
  .dev_sel_o    (dev_sel_o),
  .dev_present_i(dev_present_i),
  .addr_word    (addr_word)
);

// File: tb/test_cfg_port_decoder.sv
`timescale 1ns/1ps
module test_cfg_port_decoder;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          io_valid = 1'b0, io_we = 1'b0;
  logic [15:0]   io_addr = '0;
  logic [31:0]   io_wdata = '0, io_rdata;
  logic          dev_req, dev_we;
  logic [NS-1:0] dev_sel;
  logic [2:0]    dev_func;
  logic [7:0]    dev_offset, dev_wdata;
  logic [NS*8-1:0] dev_rdata;
  logic [NS-1:0] dev_present;

  always #4 clk = ~clk;

  cfg_port_decoder i_cfg_port_decoder (
    .clk_i(clk), .rst_ni(rst_n), .io_valid_i(io_valid), .io_we_i(io_we),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .dev_req_o(dev_req), .dev_we_o(dev_we), .dev_sel_o(dev_sel),
    .dev_func_o(dev_func), .dev_offset_o(dev_offset), .dev_wdata_o(dev_wdata),
    .dev_rdata_i(dev_rdata), .dev_present_i(dev_present)
  );

  typedef struct {
    string       tag;
    bit          req;
    bit          we;
    logic [NS-1:0] sel;
    logic [2:0]  func;
    logic [7:0]  off;
    logic [7:0]  wd;
    bit          chk_rd;
    logic [31:0] rd;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // shadow of the address word
  bit       sh_en;
  bit [7:0] sh_bus, sh_idx;
  bit [4:0] sh_dev;
  bit [2:0] sh_func;

  function automatic logic [7:0] slot_byte(int s);
    return 8'((s * 7 + 3) & 8'hFF);
  endfunction
  function automatic bit slot_here(int s);
    return (s % 3) != 2;
  endfunction

  initial begin
    for (int s = 0; s < NS; s++) begin
      dev_rdata[s*8 +: 8] = slot_byte(s);
      dev_present[s]      = slot_here(s);
    end
  end

  task automatic drive(bit we, logic [15:0] a, logic [31:0] d, exp_t e);
    @(negedge clk);
    io_valid = 1'b1; io_we = we; io_addr = a; io_wdata = d;
    q.push_back(e);
    @(negedge clk);
    io_valid = 1'b0; io_we = 1'b0;
  endtask

  function automatic exp_t quiet(string tag);
    exp_t e;
    e.tag = tag; e.req = 0; e.we = 0; e.sel = '0; e.func = '0;
    e.off = '0; e.wd = '0; e.chk_rd = 0; e.rd = '0;
    return e;
  endfunction

  task automatic set_addr(bit en, bit [7:0] bus, bit [4:0] dev, bit [2:0] fn,
                          bit [7:0] idx, bit [6:0] junk);
    exp_t e = quiet("R2 addr write");
    sh_en = en; sh_bus = bus; sh_dev = dev; sh_func = fn; sh_idx = idx;
    drive(1'b1, 16'h0CF8, {en, junk, bus, dev, fn, idx}, e);
  endtask

  task automatic read_addr(string tag);
    exp_t e = quiet(tag);
    e.chk_rd = 1;
    e.rd = {sh_en, 7'h0, sh_bus, sh_dev, sh_func, sh_idx};
    drive(1'b0, 16'h0CF8, 32'h0, e);
  endtask

  task automatic win(bit we, int k, logic [7:0] wd, string tag);
    exp_t e = quiet(tag);
    bit fwd = sh_en && (sh_bus == 0);
    e.req = fwd;
    if (fwd) begin
      e.we = we; e.sel = NS'(1) << sh_dev; e.func = sh_func;
      e.off = sh_idx | 8'(k); e.wd = we ? wd : 8'h0;
    end
    e.chk_rd = !we;
    e.rd = (fwd && slot_here(int'(sh_dev))) ? {24'h0, slot_byte(int'(sh_dev))}
                                            : 32'h0000_00FF;
    drive(we, 16'h0CFC + 16'(k), {24'hABCDEF, wd}, e);
  endtask

  task automatic other(bit we, logic [15:0] a, string tag);
    exp_t e = quiet(tag);
    e.chk_rd = !we; e.rd = 32'hFFFF_FFFF;
    drive(we, a, 32'hFFFF_FFFF, e);
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      #1;
      checks++;
      if (dev_req !== e.req || dev_sel !== e.sel || dev_we !== e.we ||
          (e.req && (dev_func !== e.func || dev_offset !== e.off || dev_wdata !== e.wd)) ||
          (e.chk_rd && io_rdata !== e.rd)) begin
        errors++;
        $display("FAIL %s: req=%0b sel=%h we=%0b func=%0d off=%h wd=%h rd=%h exp req=%0b sel=%h we=%0b func=%0d off=%h wd=%h rd=%h",
                 e.tag, dev_req, dev_sel, dev_we, dev_func, dev_offset, dev_wdata, io_rdata,
                 e.req, e.sel, e.we, e.func, e.off, e.wd, e.rd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    read_addr("R1 reset readback");
    win(1'b0, 0, 8'h00, "R5 read while disabled after reset");
    // R2: latch and readback, junk in 30:24
    set_addr(1'b1, 8'h00, 5'd4, 3'd3, 8'h40, 7'h7F);
    read_addr("R2 readback masked");
    // R3/R4: each lane
    for (int k = 0; k < 4; k++) win(1'b1, k, 8'h10 + 8'(k), "R4 forwarded write lane");
    win(1'b0, 2, 8'h00, "R3 R7 read present slot 4");
    set_addr(1'b1, 8'h00, 5'd5, 3'd7, 8'h41, 7'h00);
    win(1'b1, 2, 8'h5A, "R3 offset index OR lane");
    win(1'b0, 1, 8'h00, "R7 read absent slot 5");
    set_addr(1'b1, 8'h00, 5'd31, 3'd1, 8'hFC, 7'h01);
    read_addr("R2 readback slot 31");
    win(1'b0, 3, 8'h00, "R7 read top slot 31");
    for (int d = 0; d < 8; d++) begin
      set_addr(1'b1, 8'h00, 5'(d * 3 + 1), 3'(d), 8'(d * 16), 7'h00);
      win(1'b0, d % 4, 8'h00, "R7 read slot sweep");
    end
    // R6: nonzero bus
    set_addr(1'b1, 8'h03, 5'd4, 3'd0, 8'h08, 7'h00);
    win(1'b1, 0, 8'h77, "R6 write dropped bus 3");
    win(1'b0, 1, 8'h00, "R6 read bus 3");
    // R5: enable clear
    set_addr(1'b0, 8'h00, 5'd4, 3'd2, 8'h10, 7'h00);
    win(1'b1, 0, 8'h66, "R5 write dropped disabled");
    win(1'b0, 3, 8'h00, "R5 read disabled");
    read_addr("R2 readback disabled");
    // R8: other ports
    other(1'b1, 16'h0CF9, "R8 write near port");
    other(1'b1, 16'h0CFB, "R8 write other port");
    read_addr("R8 address word unchanged");
    other(1'b0, 16'h0080, "R8 read unclaimed");
    other(1'b0, 16'h0D00, "R8 read above window");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule